// File: doc/BRIEF.md
# Priority Interrupt Arbiter

This block gathers interrupt requests from a parameterised number of devices, eight by default. Each device carries a 3-bit urgency level, where 0 is the least urgent and 7 the most. On every cycle the block finds the most urgent pending device. If two pending devices share a level, the lower device number wins. The block then compares the winner's level with the processor's current level. It raises an interrupt toward the processor only when the winner is strictly more urgent than the running program.

The posted device number and level are registered. They stay unchanged until the processor accepts the interrupt with a one-cycle `take` pulse at an instruction boundary, or until the posted device withdraws its request. A controller of three named states runs the sequence:

- **IDLE**: nothing is posted and all outputs are zero. IDLE goes to POSTED, through the transition *post*, when a qualifying winner exists.
- **POSTED**: the interrupt is held. POSTED goes to TAKEN, through the transition *accept*, on `take`. Otherwise, if the posted device drops its request, it goes back to IDLE through the transition *withdraw*.
- **TAKEN**: a single cycle with all outputs zero. It lets the processor raise its own level before arbitration starts again. TAKEN always goes to IDLE, through the transition *resume*.

Top module: `irq_arb_top`

## Requirements
- R1: While `rst_n` is low, `irq`, `irq_idx` and `irq_lvl` are all zero.
- R2: Among the pending devices, the posted one has the numerically largest level. Device i takes its level from bits [3i+2:3i] of `dev_lvl`.
- R3: When pending devices tie on the largest level, the lowest device number is posted.
- R4: An interrupt is posted only if the winner's level is strictly greater than `cur_lvl`. An equal or lower level leaves `irq` low.
- R5: Whenever `irq` is low, `irq_idx` and `irq_lvl` are zero.
- R6: If a qualifying winner is present in IDLE before a clock edge, `irq`, `irq_idx` and `irq_lvl` show it right after that edge.
- R7: While posted, `irq_idx` and `irq_lvl` do not change, even if a more urgent request arrives or `cur_lvl` changes.
- R8: `take` seen high while posted drops `irq` after that edge. The outputs stay zero for that cycle and the next one, so a new interrupt can appear no earlier than the second edge after the take edge.
- R9: If the posted device's request is low at an edge while posted, and `take` is low, `irq` is low after that edge. Arbitration then resumes from IDLE.
- R10: `take` while nothing is posted has no effect. A request present at the same edge is posted as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_DEV | Request line per device, high means pending |
| dev_lvl | input | N_DEV*LVL_W | Packed per-device urgency levels, device i at [LVL_W*i +: LVL_W] |
| cur_lvl | input | LVL_W | Urgency level of the running program |
| take | input | 1 | One-cycle pulse: processor accepts the posted interrupt |
| irq | output | 1 | Interrupt posted to the processor |
| irq_idx | output | $clog2(N_DEV) | Number of the posted device, zero when idle |
| irq_lvl | output | LVL_W | Level of the posted device, zero when idle |

## Verification
A controller stuck in POSTED would keep `irq` high after a take, and this appears on the first edge after the pulse. A controller that skips TAKEN would re-post one cycle too early. A corrupted held number or level shows at once as a change of `irq_idx` or `irq_lvl` while `irq` stays high. Because of this, a behavioural model that tracks the three states is compared against all three outputs on every cycle. Directed sequences steer the controller through every transition, including ties, equal levels and a take that arrives while idle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POSTED = 2'd1,
        ST_TAKEN  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_DEV = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(N_DEV)
) (
    input  logic [N_DEV-1:0]       req,
    input  logic [N_DEV*LVL_W-1:0] dev_lvl,
    output logic                   any,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_lvl
);

    logic [LVL_W-1:0] lvl_a [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_unpack
        assign lvl_a[g] = dev_lvl[g*LVL_W +: LVL_W];
    end

    // Scan upward; replace only on a strictly larger level so ties keep the lower index.
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (req[i] && (!any || (lvl_a[i] > win_lvl))) begin
                any     = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl_a[i];
            end
        end
    end

endmodule

// File: rtl/irq_lvl_cmp.sv
module irq_lvl_cmp #(
    parameter int LVL_W = 3
) (
    input  logic             any,
    input  logic [LVL_W-1:0] cand_lvl,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             outranks
);

    assign outranks = any && (cand_lvl > cur_lvl);

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int N_DEV = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(N_DEV)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DEV-1:0]       req,
    input  logic [N_DEV*LVL_W-1:0] dev_lvl,
    input  logic [LVL_W-1:0]       cur_lvl,
    input  logic                   take,
    output logic                   irq,
    output logic [IDX_W-1:0]       irq_idx,
    output logic [LVL_W-1:0]       irq_lvl
);

    arb_state_e       state_q, state_d;
    logic             cand_any;
    logic [IDX_W-1:0] cand_idx;
    logic [LVL_W-1:0] cand_lvl;
    logic             cand_ok;
    logic             irq_q;
    logic [IDX_W-1:0] idx_q;
    logic [LVL_W-1:0] lvl_q;

    irq_prio_pick #(.N_DEV(N_DEV), .LVL_W(LVL_W)) u_pick (
        .req     (req),
        .dev_lvl (dev_lvl),
        .any     (cand_any),
        .win_idx (cand_idx),
        .win_lvl (cand_lvl)
    );

    irq_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
        .any      (cand_any),
        .cand_lvl (cand_lvl),
        .cur_lvl  (cur_lvl),
        .outranks (cand_ok)
    );

    // Transitions: post, accept, withdraw, resume.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cand_ok) state_d = ST_POSTED;
            ST_POSTED: begin
                if (take)              state_d = ST_TAKEN;
                else if (!req[idx_q])  state_d = ST_IDLE;
            end
            ST_TAKEN:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            idx_q <= '0;
            lvl_q <= '0;
        end else begin
            irq_q <= (state_d == ST_POSTED);
            if (state_q != ST_POSTED && state_d == ST_POSTED) begin
                idx_q <= cand_idx;
                lvl_q <= cand_lvl;
            end else if (state_d != ST_POSTED) begin
                idx_q <= '0;
                lvl_q <= '0;
            end
        end
    end

    assign irq     = irq_q;
    assign irq_idx = idx_q;
    assign irq_lvl = lvl_q;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int N_DEV = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(N_DEV)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_DEV-1:0]       req,
    input logic [LVL_W-1:0]       cur_lvl,
    input logic                   take,
    input logic                   irq,
    input logic [IDX_W-1:0]       irq_idx,
    input logic [LVL_W-1:0]       irq_lvl
);

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_idx == '0 && irq_lvl == '0));

    a_r4_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (irq_lvl > $past(cur_lvl)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq)) |-> ($stable(irq_idx) && $stable(irq_lvl)));

    a_r8_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && take) |=> !irq);

    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && take) |=> ##1 !irq);

    a_r9_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !take && !req[irq_idx]) |=> !irq);

endmodule

bind irq_arb_top irq_arb_chk #(.N_DEV(N_DEV), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .cur_lvl (cur_lvl),
    .take    (take),
    .irq     (irq),
    .irq_idx (irq_idx),
    .irq_lvl (irq_lvl)
);

// File: tb/tb_irq_arb_top.sv
module tb_irq_arb_top;

    localparam int N  = 8;
    localparam int LW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*LW-1:0] dev_lvl;
    logic [LW-1:0] cur_lvl = '0;
    logic          take = 1'b0;
    logic          irq;
    logic [IW-1:0] irq_idx;
    logic [LW-1:0] irq_lvl;

    int lvl_of [N] = '{2, 5, 5, 7, 0, 3, 6, 1};

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    int  m_mode = 0;   // 0 idle, 1 posted, 2 taken
    int  m_idx = 0;
    int  m_lvl = 0;
    int  w;

    always #5 clk = ~clk;

    initial begin
        for (int i = 0; i < N; i++) dev_lvl[i*LW +: LW] = LW'(lvl_of[i]);
    end

    irq_arb_top #(.N_DEV(N), .LVL_W(LW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .dev_lvl (dev_lvl),
        .cur_lvl (cur_lvl),
        .take    (take),
        .irq     (irq),
        .irq_idx (irq_idx),
        .irq_lvl (irq_lvl)
    );

    // Highest level wins; search from the top index with >= so the lowest index survives a tie.
    function automatic int pick();
        int best = -1;
        for (int i = N - 1; i >= 0; i--)
            if (req[i] && (best < 0 || lvl_of[i] >= lvl_of[best])) best = i;
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; m_idx <= 0; m_lvl <= 0;
        end else begin
            w = pick();
            case (m_mode)
                0: if (w >= 0 && lvl_of[w] > int'(cur_lvl)) begin
                       m_mode <= 1; m_idx <= w; m_lvl <= lvl_of[w];
                   end
                1: if (take) begin
                       m_mode <= 2; m_idx <= 0; m_lvl <= 0;
                   end else if (!req[m_idx]) begin
                       m_mode <= 0; m_idx <= 0; m_lvl <= 0;
                   end
                default: m_mode <= 0;
            endcase
        end
    end

    task automatic expect_out(string tag, bit e_irq, int e_idx, int e_lvl);
        n_cmp++;
        if (irq !== e_irq || int'(irq_idx) != e_idx || int'(irq_lvl) != e_lvl) begin
            n_bad++;
            $display("FAIL %s: got irq=%0b idx=%0d lvl=%0d, expected irq=%0b idx=%0d lvl=%0d",
                     tag, irq, irq_idx, irq_lvl, e_irq, e_idx, e_lvl);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on)
            expect_out(m_mode == 1 ? "R7 model" : (m_mode == 2 ? "R8 model" : "R4 model"),
                       m_mode == 1, m_idx, m_lvl);
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        expect_out("R1", 1'b0, 0, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(); expect_out("R5", 1'b0, 0, 0);

        req = 8'b0010_0011;
        tick(); expect_out("R6", 1'b1, 1, 5);
        expect_out("R2", 1'b1, 1, 5);

        req[3] = 1'b1; cur_lvl = 3'd6;
        tick(); expect_out("R7", 1'b1, 1, 5);

        cur_lvl = 3'd0; take = 1'b1;
        tick(); take = 1'b0; expect_out("R8", 1'b0, 0, 0);
        tick(); expect_out("R8", 1'b0, 0, 0);
        tick(); expect_out("R8", 1'b1, 3, 7);

        req[3] = 1'b0;
        tick(); expect_out("R9", 1'b0, 0, 0);
        tick(); expect_out("R9", 1'b1, 1, 5);

        req = '0;
        tick();
        req = 8'b0000_0010; cur_lvl = 3'd5;
        for (int k = 0; k < 3; k++) begin
            tick(); expect_out("R4", 1'b0, 0, 0);
        end
        cur_lvl = 3'd4;
        tick(); expect_out("R4", 1'b1, 1, 5);

        req = '0; tick();
        req = 8'b0000_0110; cur_lvl = 3'd0;
        tick(); expect_out("R3", 1'b1, 1, 5);
        req = '0; tick();
        req = 8'b1001_0000;
        tick(); expect_out("R2", 1'b1, 7, 1);

        req = '0; tick();
        take = 1'b1; req = 8'b0100_0000;
        tick(); take = 1'b0; expect_out("R10", 1'b1, 6, 6);

        req = '0; tick();
        req = 8'b0001_0000;
        tick(); expect_out("R4", 1'b0, 0, 0);

        for (int k = 0; k < 400; k++) begin
            tick();
            req     = N'($urandom) & N'($urandom);
            cur_lvl = LW'($urandom);
            take    = ($urandom % 4) == 0;
        end
        tick();
        done = 1'b1;
        cmp_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule